// File: doc/BRIEF.md
# Synchronous Burst SRAM with Flow-Through Read

This block is a single-clock synchronous SRAM. Each word holds 36 bits, split into four 9-bit byte lanes. Every control, address and write-data input is captured on the rising clock edge. Three chip selects and two address strobes classify each cycle as one of four types: deselect, burst start, burst step or burst hold.

A strobe driven by a processor always starts a read burst. A strobe driven by a controller starts a burst that can read or write. When neither strobe is active, a step input moves an internal 2-bit burst counter forward, either in linear order or in interleaved order, or leaves it where it is.

Reads are flow-through. The word at the captured address appears on the data output in the same cycle that follows the sampling edge, with no output register in between. An asynchronous output-enable input gates a drive-enable output, which stands in for a tri-state pin.

Top module: `sbsram_ft`

## Requirements
- R1: The part is selected only when `sel_a_n_i`=0, `sel_b_i`=1 and `sel_c_n_i`=0. Any other combination, sampled while a qualified strobe is low, is a deselect cycle. A deselect cycle writes nothing, keeps the burst address, and leaves `drv_o` low for the following cycle.
- R2: While `sel_a_n_i`=1, `strb_cpu_n_i` is ignored. In that case `strb_ctl_n_i`=0 gives a deselect, and `strb_ctl_n_i`=1 gives a burst step or hold, chosen by `step_n_i`.
- R3: With the part selected, `strb_cpu_n_i`=0 starts a read burst at `addr_i`, and all write inputs are ignored in that cycle.
- R4: With the part selected, `strb_cpu_n_i`=1 and `strb_ctl_n_i`=0 start a burst at `addr_i`. The cycle is a write when the write decode is active and a read otherwise.
- R5: With both strobes high, `step_n_i`=0 moves to the next burst address and `step_n_i`=1 keeps the current one. Either kind of cycle can read or write.
- R6: Write decode. `wr_all_n_i`=0 writes all four lanes. Otherwise, when `wr_byte_n_i`=0, each bit k of `lane_wr_n_i` that is 0 writes lane k, which is data bits 9k to 9k+8. In every other case the cycle is a read.
- R7: Flow-through read. After the edge that samples a cycle, `rdata_o` shows the word at that cycle's address before the next edge. A word written at one edge reads back as the new data.
- R8: `drv_o` is high when the previous sampled cycle was a selected read and `out_en_n_i` is 0 at the present time; `out_en_n_i` acts without waiting for a clock edge. A write cycle or a deselect cycle forces `drv_o` low until a later read cycle.
- R9: Burst order. The low two address bits run from the start offset s as (s+n) mod 4 when `burst_ilv_i`=0 at the start, or as s XOR n when it is 1. The upper address bits never change within a burst.
- R10: While `rst_n` is low, `drv_o` is low and the burst address is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | External word address |
| wdata_i | input | 36 | Write data, four 9-bit lanes |
| sel_a_n_i | input | 1 | Primary chip select, active low |
| sel_b_i | input | 1 | Second chip select, active high |
| sel_c_n_i | input | 1 | Third chip select, active low |
| strb_cpu_n_i | input | 1 | Processor address strobe, active low |
| strb_ctl_n_i | input | 1 | Controller address strobe, active low |
| step_n_i | input | 1 | Burst advance, active low |
| wr_all_n_i | input | 1 | Write all lanes, active low |
| wr_byte_n_i | input | 1 | Byte-write qualifier, active low |
| lane_wr_n_i | input | 4 | Per-lane write enables, active low |
| burst_ilv_i | input | 1 | Burst order at start: 1 interleaved, 0 linear |
| out_en_n_i | input | 1 | Asynchronous output enable, active low |
| rdata_o | output | 36 | Flow-through read data |
| drv_o | output | 1 | Data output drive enable |

## Verification
The burst address register feeds the read port directly. A wrong counter value or a wrong burst order therefore shows up as the wrong word on `rdata_o` in the same cycle as the faulty step, as long as that cycle is a read. A write that lands on the wrong lane or address stays hidden until that word is read again, so the bench reads back after each write pattern. A read-flag error is visible on `drv_o` in the cycle right after the edge that set it. The bench also toggles `out_en_n_i` between edges to expose any clocked behaviour on that input.

// File: rtl/sbsram_pkg.sv
package sbsram_pkg;
  typedef enum logic [1:0] {
    CYC_DESEL = 2'd0,
    CYC_BEGIN = 2'd1,
    CYC_NEXT  = 2'd2,
    CYC_HOLD  = 2'd3
  } cyc_e;
endpackage

// File: rtl/sbsram_decode.sv
module sbsram_decode
  import sbsram_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic             sel_a_n_i,
  input  logic             sel_b_i,
  input  logic             sel_c_n_i,
  input  logic             strb_cpu_n_i,
  input  logic             strb_ctl_n_i,
  input  logic             step_n_i,
  input  logic             wr_all_n_i,
  input  logic             wr_byte_n_i,
  input  logic [LANES-1:0] lane_wr_n_i,
  output cyc_e             cyc_o,
  output logic [LANES-1:0] lane_we_o
);
  logic             selected;
  logic             cpu_start;
  logic             any_strobe;
  logic [LANES-1:0] raw_we;

  always_comb begin
    selected   = !sel_a_n_i && sel_b_i && !sel_c_n_i;
    // processor strobe only counts while the primary select is low
    cpu_start  = !strb_cpu_n_i && !sel_a_n_i;
    any_strobe = cpu_start || !strb_ctl_n_i;

    if (!wr_all_n_i)       raw_we = '1;
    else if (!wr_byte_n_i) raw_we = ~lane_wr_n_i;
    else                   raw_we = '0;

    if (any_strobe && !selected) begin
      cyc_o     = CYC_DESEL;
      lane_we_o = '0;
    end else if (cpu_start) begin
      cyc_o     = CYC_BEGIN;
      lane_we_o = '0;
    end else if (!strb_ctl_n_i) begin
      cyc_o     = CYC_BEGIN;
      lane_we_o = raw_we;
    end else begin
      cyc_o     = step_n_i ? CYC_HOLD : CYC_NEXT;
      lane_we_o = raw_we;
    end
  end
endmodule

// File: rtl/sbsram_burst_ctr.sv
module sbsram_burst_ctr
  import sbsram_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int BURST_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  cyc_e              cyc_i,
  input  logic [ADDR_W-1:0] ext_addr_i,
  input  logic              ilv_i,
  output logic [ADDR_W-1:0] eff_addr_o,
  output logic [ADDR_W-1:0] cur_addr_o
);
  localparam int HI_W = ADDR_W - BURST_W;

  logic [HI_W-1:0]    hi_q, hi_d;
  logic [BURST_W-1:0] start_q, start_d, cnt_q, cnt_d;
  logic               ilv_q, ilv_d;
  logic               upd_en;

  function automatic logic [BURST_W-1:0] seq_off(input logic il,
                                                  input logic [BURST_W-1:0] s,
                                                  input logic [BURST_W-1:0] c);
    return il ? (s ^ c) : (s + c);
  endfunction

  always_comb begin
    hi_d    = hi_q;
    start_d = start_q;
    cnt_d   = cnt_q;
    ilv_d   = ilv_q;
    upd_en  = 1'b0;
    case (cyc_i)
      CYC_BEGIN: begin
        hi_d    = ext_addr_i[ADDR_W-1:BURST_W];
        start_d = ext_addr_i[BURST_W-1:0];
        cnt_d   = '0;
        ilv_d   = ilv_i;
        upd_en  = 1'b1;
      end
      CYC_NEXT: begin
        cnt_d  = cnt_q + 1'b1;
        upd_en = 1'b1;
      end
      default: ;
    endcase
    cur_addr_o = {hi_q, seq_off(ilv_q, start_q, cnt_q)};
    eff_addr_o = {hi_d, seq_off(ilv_d, start_d, cnt_d)};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q    <= '0;
      start_q <= '0;
      cnt_q   <= '0;
      ilv_q   <= 1'b0;
    end else if (upd_en) begin
      hi_q    <= hi_d;
      start_q <= start_d;
      cnt_q   <= cnt_d;
      ilv_q   <= ilv_d;
    end
  end

  // R5
  hold_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_i == CYC_HOLD || cyc_i == CYC_DESEL) |=> $stable(cur_addr_o));
  // R4
  begin_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_i == CYC_BEGIN) |=> cur_addr_o == $past(ext_addr_i));
  // R9
  step_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_i == CYC_NEXT) |=> (cnt_q == $past(cnt_q) + 1'b1) && $stable(hi_q));
endmodule

// File: rtl/sbsram_lanes.sv
module sbsram_lanes #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic [LANES-1:0]        we_i,
  input  logic [ADDR_W-1:0]       waddr_i,
  input  logic [LANES*LANE_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0]       raddr_i,
  output logic [LANES*LANE_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
      if (we_i[l]) store[waddr_i] <= wdata_i[l*LANE_W +: LANE_W];
    end

    assign rdata_o[l*LANE_W +: LANE_W] = store[raddr_i];
  end
endmodule

// File: rtl/sbsram_ft.sv
module sbsram_ft
  import sbsram_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int LANES   = 4,
  parameter int LANE_W  = 9,
  parameter int BURST_W = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [LANES*LANE_W-1:0] wdata_i,
  input  logic                    sel_a_n_i,
  input  logic                    sel_b_i,
  input  logic                    sel_c_n_i,
  input  logic                    strb_cpu_n_i,
  input  logic                    strb_ctl_n_i,
  input  logic                    step_n_i,
  input  logic                    wr_all_n_i,
  input  logic                    wr_byte_n_i,
  input  logic [LANES-1:0]        lane_wr_n_i,
  input  logic                    burst_ilv_i,
  input  logic                    out_en_n_i,
  output logic [LANES*LANE_W-1:0] rdata_o,
  output logic                    drv_o
);
  cyc_e              cyc;
  logic [LANES-1:0]  lane_we;
  logic [ADDR_W-1:0] eff_addr, cur_addr;
  logic              rd_q, rd_d;

  sbsram_decode #(.LANES(LANES)) u_dec (
    .sel_a_n_i   (sel_a_n_i),
    .sel_b_i     (sel_b_i),
    .sel_c_n_i   (sel_c_n_i),
    .strb_cpu_n_i(strb_cpu_n_i),
    .strb_ctl_n_i(strb_ctl_n_i),
    .step_n_i    (step_n_i),
    .wr_all_n_i  (wr_all_n_i),
    .wr_byte_n_i (wr_byte_n_i),
    .lane_wr_n_i (lane_wr_n_i),
    .cyc_o       (cyc),
    .lane_we_o   (lane_we)
  );

  sbsram_burst_ctr #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) u_ctr (
    .clk       (clk),
    .rst_n     (rst_n),
    .cyc_i     (cyc),
    .ext_addr_i(addr_i),
    .ilv_i     (burst_ilv_i),
    .eff_addr_o(eff_addr),
    .cur_addr_o(cur_addr)
  );

  sbsram_lanes #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_mem (
    .clk    (clk),
    .we_i   (lane_we),
    .waddr_i(eff_addr),
    .wdata_i(wdata_i),
    .raddr_i(cur_addr),
    .rdata_o(rdata_o)
  );

  always_comb rd_d = (cyc != CYC_DESEL) && (lane_we == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_q <= 1'b0;
    else        rd_q <= rd_d;
  end

  assign drv_o = rd_q && !out_en_n_i;

  // R1
  desel_nowr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == CYC_DESEL) |-> (lane_we == '0));
  // R1
  desel_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == CYC_DESEL) |=> !drv_o);
  // R3
  cpu_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!strb_cpu_n_i && !sel_a_n_i && sel_b_i && !sel_c_n_i) |-> (lane_we == '0));
  // R6
  all_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_all_n_i && strb_cpu_n_i && sel_b_i && !sel_a_n_i && !sel_c_n_i) |-> (&lane_we));
  // R8
  wr_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_we != '0) |=> !drv_o);
  // R8
  oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drv_o |-> !out_en_n_i);
endmodule

// File: tb/sbsram_ft_tb_top.sv
`timescale 1ns/1ps
module sbsram_ft_tb_top;
  localparam int AW = 6;
  localparam int DW = 36;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata;
  logic          sa_n, sb, sc_n, cpu_n, ctl_n, stp_n, wa_n, wb_n, ilv, oe_n;
  logic [3:0]    lw_n;
  logic [DW-1:0] rdata;
  logic          drv;

  int checks = 0;
  int errors = 0;
  string cur_req = "R10";

  bit            m_rd;
  int            m_hi, m_st, m_cnt;
  bit            m_ilv;
  bit [DW-1:0]   mref [int];

  always #2.5 clk = ~clk;

  sbsram_ft dut_i (
    .clk(clk), .rst_n(rst_n), .addr_i(addr), .wdata_i(wdata),
    .sel_a_n_i(sa_n), .sel_b_i(sb), .sel_c_n_i(sc_n),
    .strb_cpu_n_i(cpu_n), .strb_ctl_n_i(ctl_n), .step_n_i(stp_n),
    .wr_all_n_i(wa_n), .wr_byte_n_i(wb_n), .lane_wr_n_i(lw_n),
    .burst_ilv_i(ilv), .out_en_n_i(oe_n), .rdata_o(rdata), .drv_o(drv)
  );

  function automatic int m_addr();
    int off;
    off = m_ilv ? (m_st ^ m_cnt) : ((m_st + m_cnt) % 4);
    return m_hi * 4 + off;
  endfunction

  function automatic bit [DW-1:0] pat(input int a);
    return DW'(a * 36'h0F0F1 + 36'h1234_5678_9);
  endfunction

  task automatic chk(input bit ok, input string what, input bit [DW-1:0] act, input bit [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act %h exp %h", cur_req, what, act, exp);
    end
  endtask

  task automatic model_step();
    bit sel, cpu, strobe;
    bit [3:0] mask;
    int a;
    sel    = !sa_n && sb && !sc_n;
    cpu    = !cpu_n && !sa_n;
    strobe = cpu || !ctl_n;
    if (!wa_n)      mask = 4'hF;
    else if (!wb_n) mask = ~lw_n;
    else            mask = 4'h0;
    if (strobe && !sel) begin
      m_rd = 0;
      return;
    end
    if (strobe) begin
      if (cpu) mask = 4'h0;
      m_hi  = int'(addr) / 4;
      m_st  = int'(addr) % 4;
      m_cnt = 0;
      m_ilv = ilv;
    end else if (!stp_n) begin
      m_cnt = (m_cnt + 1) % 4;
    end
    a = m_addr();
    if (mask != 0) begin
      if (!mref.exists(a)) mref[a] = '0;
      for (int k = 0; k < 4; k++)
        if (mask[k]) mref[a][k*9 +: 9] = wdata[k*9 +: 9];
    end
    m_rd = (mask == 0);
  endtask

  task automatic check_out();
    bit exp_drv;
    int a;
    exp_drv = m_rd && !oe_n;
    a = m_addr();
    chk(drv == exp_drv, "drive", DW'(drv), DW'(exp_drv));
    if (exp_drv && mref.exists(a))
      chk(rdata == mref[a], "data", rdata, mref[a]);
  endtask

  task automatic tick();
    @(posedge clk);
    if (!rst_n) begin
      m_rd = 0; m_hi = 0; m_st = 0; m_cnt = 0; m_ilv = 0;
    end else begin
      model_step();
    end
    #1;
    check_out();
    @(negedge clk);
  endtask

  task automatic run(input bit a_n, input bit b, input bit c_n, input bit p_n, input bit q_n,
                     input bit s_n, input bit g_n, input bit e_n, input bit [3:0] l_n,
                     input int ad, input bit [DW-1:0] d, input bit il);
    sa_n = a_n; sb = b; sc_n = c_n; cpu_n = p_n; ctl_n = q_n; stp_n = s_n;
    wa_n = g_n; wb_n = e_n; lw_n = l_n; addr = AW'(ad); wdata = d; ilv = il;
    tick();
  endtask

  task automatic idle_rd();
    run(1, 0, 1, 1, 1, 1, 1, 1, 4'hF, 0, '0, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog act 0 exp 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 0; oe_n = 0;
    sa_n = 1; sb = 0; sc_n = 1; cpu_n = 1; ctl_n = 1; stp_n = 1;
    wa_n = 1; wb_n = 1; lw_n = 4'hF; addr = '0; wdata = '0; ilv = 0;
    @(negedge clk);
    cur_req = "R10";
    repeat (3) tick();
    rst_n = 1;
    idle_rd();

    cur_req = "R4";
    for (int a = 0; a < 64; a++) run(0, 1, 0, 1, 0, 1, 0, 1, 4'hF, a, pat(a), 0);
    cur_req = "R7";
    idle_rd();
    idle_rd();

    cur_req = "R3";
    run(0, 1, 0, 0, 1, 1, 0, 0, 4'h0, 5, ~pat(5), 0);
    idle_rd();
    run(0, 1, 0, 0, 0, 1, 0, 0, 4'h0, 6, '0, 0);

    cur_req = "R9";
    run(0, 1, 0, 0, 1, 1, 1, 1, 4'hF, 9, '0, 0);
    repeat (4) run(1, 0, 1, 1, 1, 0, 1, 1, 4'hF, 0, '0, 0);
    run(0, 1, 0, 0, 1, 1, 1, 1, 4'hF, 9, '0, 1);
    repeat (4) run(1, 0, 1, 1, 1, 0, 1, 1, 4'hF, 0, '0, 0);
    run(0, 1, 0, 0, 1, 1, 1, 1, 4'hF, 46, '0, 1);
    repeat (4) run(0, 1, 0, 1, 1, 0, 1, 1, 4'hF, 0, '0, 1);

    cur_req = "R5";
    run(0, 1, 0, 0, 1, 1, 1, 1, 4'hF, 20, '0, 0);
    run(0, 1, 0, 1, 1, 1, 1, 1, 4'hF, 0, '0, 0);
    run(0, 1, 0, 1, 1, 1, 1, 1, 4'hF, 0, '0, 0);
    run(0, 1, 0, 1, 1, 0, 1, 0, 4'b1010, 0, 36'hFFFFFFFFF, 0);
    run(0, 1, 0, 1, 1, 1, 0, 1, 4'hF, 0, 36'h0AAAAAAAA, 0);
    cur_req = "R7";
    idle_rd();

    cur_req = "R6";
    run(0, 1, 0, 1, 0, 1, 1, 0, 4'b0110, 30, 36'h123456789, 0);
    idle_rd();
    run(0, 1, 0, 1, 0, 1, 1, 1, 4'h0, 31, 36'h0, 0);
    run(0, 1, 0, 1, 1, 1, 1, 0, 4'hF, 0, 36'h0, 0);
    run(0, 1, 0, 1, 0, 1, 1, 0, 4'b0111, 32, 36'hFEDCBA987, 0);
    idle_rd();

    cur_req = "R1";
    run(0, 0, 0, 1, 0, 1, 0, 1, 4'hF, 33, 36'h0, 0);
    idle_rd();
    run(0, 1, 1, 0, 1, 1, 0, 1, 4'hF, 34, 36'h0, 0);
    idle_rd();
    run(1, 1, 0, 1, 0, 1, 1, 1, 4'hF, 35, 36'h0, 0);
    run(0, 1, 0, 1, 0, 1, 1, 1, 4'hF, 33, 36'h0, 0);

    cur_req = "R2";
    run(1, 0, 1, 0, 1, 0, 1, 1, 4'hF, 50, '0, 0);
    run(1, 0, 1, 0, 1, 0, 1, 1, 4'hF, 50, '0, 0);
    run(1, 1, 0, 1, 0, 1, 1, 1, 4'hF, 50, '0, 0);
    idle_rd();

    cur_req = "R8";
    run(0, 1, 0, 0, 1, 1, 1, 1, 4'hF, 40, '0, 0);
    oe_n = 1; #0.5; check_out();
    oe_n = 0; #0.5; check_out();
    run(1, 0, 1, 1, 1, 1, 0, 1, 4'hF, 0, 36'h1, 0);
    run(1, 0, 1, 1, 1, 0, 1, 1, 4'hF, 0, '0, 0);

    cur_req = "mixed";
    for (int i = 0; i < 400; i++) begin
      oe_n = ($urandom_range(0, 4) == 0);
      run($urandom_range(0, 5) == 0, $urandom_range(0, 5) != 0, $urandom_range(0, 5) == 0,
          $urandom_range(0, 3) != 0, $urandom_range(0, 2) != 0, $urandom_range(0, 1) != 0,
          $urandom_range(0, 5) != 0, $urandom_range(0, 1) != 0, 4'($urandom_range(0, 15)),
          $urandom_range(0, 63), {4'($urandom), 32'($urandom)}, $urandom_range(0, 1) != 0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule